// File: doc/BRIEF.md
# Delayed Lockstep Comparator with Self-Test

The block wraps a small registered arithmetic unit (a W-bit adder) in a lockstep pair. The main copy works on the live operands. A shadow copy sees the same operands one register stage later and runs on its own clock-enable. The main copy's result also passes through one delay stage, so the two results meet in the same cycle. A transient that hits both copies in one cycle therefore strikes them at different points of the computation and shows up as a mismatch. The shadow copy, its input stage, the result delay stage and the comparator all advance only on the shadow enable. A designer drives the two enables from separate clock gaters.

In mission mode, a valid mismatch sets a sticky fault flag. Only an explicit clear input removes it. A processor can prove the comparator healthy by starting a self-test. The quick flavour flips one bit of the shadow result at a time and expects each flip to be caught. The full flavour pushes a computed vector sequence through both copies and expects silence. While a test runs, mission fault reporting is masked. The verdict (done plus pass) is held until the next start.

The self-test controller has four states:
- `ST_IDLE`: waits for `st_start`. It goes to `ST_FLIP` (quick) or `ST_SEQ` (full).
- `ST_FLIP`: walks the flip position from 0 to W-1, then goes to `ST_QUIET`.
- `ST_QUIET`: one cycle with no flip, then back to `ST_IDLE`, where the verdict is registered.
- `ST_SEQ`: counts NVEC+2 cycles, then goes back to `ST_IDLE`, where the verdict is registered.

Top module: `lockstep_cmp`

## Requirements
- R1: `res_o` is the main copy's result: on a rising edge with `en_main` high it becomes (`in_a` + `in_b`) mod 2^W. With `en_main` low it holds. After reset it is 0.
- R2: When both enables stay high and nothing disturbs either copy, `fault_o` never rises, for any operand sequence.
- R3: Comparison is active only after both enables have been high together on two edges since reset, or since the last edge on which both were low. Before that, no mismatch is reported. This covers the case where the main copy ran alone before the shadow copy was enabled.
- R4: In mission mode (`st_busy` low), a mismatch during active comparison sets `fault_o` on the next edge. This includes a mismatch caused by `en_main` dropping for one cycle while the operands change. `fault_o` then stays set whatever follows.
- R5: `fault_clr` high on an edge forces `fault_o` to 0 after that edge. The clear wins over a mismatch in the same cycle.
- R6: `st_start` in idle launches a test: `st_detail`=0 selects the quick test, 1 selects the full test. `st_busy` is high while the test runs. A `st_start` that arrives while busy is ignored.
- R7: The quick test spends W cycles with one shadow-result bit flipped (bit 0 first) and then one cycle without a flip. It passes only if every flipped cycle was flagged and the quiet cycle was not. `st_done` rises W+2 edges after the start edge.
- R8: The full test feeds both copies the vectors a_k = (37k+11) mod 2^W and b_k = bitwise-not of (13k mod 2^W), for k = 0..NVEC-1. After the (k+2)-th edge counted from the start edge, `res_o` = a_k+b_k. The test passes only if no mismatch occurs over NVEC+2 cycles. `st_done` rises NVEC+3 edges after the start edge.
- R9: `fault_o` never rises because of a mismatch seen while a test is running.
- R10: `st_done` and `st_pass` hold their values until the next accepted start. That start clears `st_done` on its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_main | input | 1 | Clock enable of the main copy |
| en_chk | input | 1 | Clock enable of the shadow copy, delay stages and comparator |
| in_a | input | W | Operand A |
| in_b | input | W | Operand B |
| res_o | output | W | Main copy result |
| fault_clr | input | 1 | Clears the sticky fault flag |
| fault_o | output | 1 | Sticky mission-mode fault flag |
| st_start | input | 1 | Self-test start request |
| st_detail | input | 1 | 0 = quick comparator test, 1 = full vector test |
| st_busy | output | 1 | Self-test running |
| st_done | output | 1 | Self-test finished, verdict valid |
| st_pass | output | 1 | Self-test verdict |

## Verification
The bench sweeps the adder over several hundred operand pairs and checks every result. It then attacks the alignment corners.

- Main copy running alone before the shadow copy is enabled: a design without the two-edge warm-up would report a fault here.
- Single-cycle drop of one gater while operands change: a design that compared the wrong stages would miss this.
- Clear arriving beside live traffic: a design with the wrong priority would leave the flag set.

Each self-test flavour runs once healthy and once sabotaged. The quick test is sabotaged with the shadow gater held off, and the full test with a main-gater glitch. Latencies are checked to the exact edge. A controller that accepted a second start, leaked mismatches to `fault_o`, or lost its verdict would break these checks.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLIP  = 2'd1,
        ST_QUIET = 2'd2,
        ST_SEQ   = 2'd3
    } lsc_state_e;

    localparam int unsigned VEC_A_MUL = 37;
    localparam int unsigned VEC_A_ADD = 11;
    localparam int unsigned VEC_B_MUL = 13;

endpackage

// File: rtl/lsc_unit.sv
module lsc_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_o <= '0;
        end else if (en) begin
            y_o <= a_i + b_i;
        end
    end
endmodule

// File: rtl/lsc_shadow.sv
module lsc_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_main,
    input  logic         en_chk,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] y_main,
    input  logic [W-1:0] flip_i,
    output logic         mism_o
);
    localparam logic [1:0] WARM_FULL = 2'd2;

    logic [W-1:0] a_d, b_d, y_pd, y_c;
    logic [1:0]   warm;

    // input delay for the shadow copy, result delay for the main copy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_d  <= '0;
            b_d  <= '0;
            y_pd <= '0;
        end else if (en_chk) begin
            a_d  <= a_i;
            b_d  <= b_i;
            y_pd <= y_main;
        end
    end

    // warm-up: both pipelines must be filled before results are trusted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= '0;
        end else if (en_main && en_chk) begin
            if (warm != WARM_FULL) warm <= warm + 2'd1;
        end else if (!en_main && !en_chk) begin
            warm <= '0;
        end
    end

    lsc_unit #(.W(W)) u_dup (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_chk),
        .a_i   (a_d),
        .b_i   (b_d),
        .y_o   (y_c)
    );

    assign mism_o = en_chk && (warm == WARM_FULL) && (y_pd != (y_c ^ flip_i));
endmodule

// File: rtl/lsc_selftest.sv
module lsc_selftest
    import lsc_pkg::*;
#(
    parameter int W    = 8,
    parameter int NVEC = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         detail_i,
    input  logic         mism_i,
    output logic         drive_o,
    output logic [W-1:0] va_o,
    output logic [W-1:0] vb_o,
    output logic [W-1:0] flip_o,
    output logic         busy_o,
    output logic         done_o,
    output logic         pass_o
);
    localparam int IW = (W > 2) ? $clog2(W) : 1;
    localparam int CW = $clog2(NVEC + 3);
    localparam logic [IW-1:0] IDX_LAST = IW'(W - 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(NVEC + 1);
    localparam logic [CW-1:0] CNT_VEC  = CW'(NVEC);

    lsc_state_e  state_q, state_d;
    logic [IW-1:0] idx_q;
    logic [CW-1:0] cnt_q;
    logic          err_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        flip_o  = '0;
        drive_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = detail_i ? ST_SEQ : ST_FLIP;
            end
            ST_FLIP: begin
                flip_o = W'(1) << idx_q;
                if (idx_q == IDX_LAST) state_d = ST_QUIET;
            end
            ST_QUIET: begin
                state_d = ST_IDLE;
            end
            ST_SEQ: begin
                drive_o = (cnt_q < CNT_VEC);
                if (cnt_q == CNT_LAST) state_d = ST_IDLE;
            end
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);
    assign va_o   = W'(32'(cnt_q) * VEC_A_MUL + VEC_A_ADD);
    assign vb_o   = ~W'(32'(cnt_q) * VEC_B_MUL);

    // counters and verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            cnt_q  <= '0;
            err_q  <= 1'b0;
            done_o <= 1'b0;
            pass_o <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        idx_q  <= '0;
                        cnt_q  <= '0;
                        err_q  <= 1'b0;
                        done_o <= 1'b0;
                        pass_o <= 1'b0;
                    end
                end
                ST_FLIP: begin
                    if (!mism_i) err_q <= 1'b1;
                    idx_q <= idx_q + IW'(1);
                end
                ST_QUIET: begin
                    done_o <= 1'b1;
                    pass_o <= !(err_q || mism_i);
                end
                ST_SEQ: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == CNT_LAST) begin
                        done_o <= 1'b1;
                        pass_o <= !(err_q || mism_i);
                    end else if (mism_i) begin
                        err_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    p_busy_not_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);

    p_verdict_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(pass_o)));

    p_flip_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flip_o));
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp #(
    parameter int W    = 8,
    parameter int NVEC = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_main,
    input  logic         en_chk,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] res_o,
    input  logic         fault_clr,
    output logic         fault_o,
    input  logic         st_start,
    input  logic         st_detail,
    output logic         st_busy,
    output logic         st_done,
    output logic         st_pass
);
    logic         drive, mism;
    logic [W-1:0] va, vb, flip, op_a, op_b;

    assign op_a = drive ? va : in_a;
    assign op_b = drive ? vb : in_b;

    lsc_unit #(.W(W)) u_main (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_main),
        .a_i   (op_a),
        .b_i   (op_b),
        .y_o   (res_o)
    );

    lsc_shadow #(.W(W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_main (en_main),
        .en_chk  (en_chk),
        .a_i     (op_a),
        .b_i     (op_b),
        .y_main  (res_o),
        .flip_i  (flip),
        .mism_o  (mism)
    );

    lsc_selftest #(.W(W), .NVEC(NVEC)) u_test (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (st_start),
        .detail_i (st_detail),
        .mism_i   (mism),
        .drive_o  (drive),
        .va_o     (va),
        .vb_o     (vb),
        .flip_o   (flip),
        .busy_o   (st_busy),
        .done_o   (st_done),
        .pass_o   (st_pass)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                fault_o <= 1'b0;
        else if (fault_clr)        fault_o <= 1'b0;
        else if (mism && !st_busy) fault_o <= 1'b1;
    end

    p_fault_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !fault_clr) |=> fault_o);

    p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr |=> !fault_o);

    p_masked_in_test_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> $past(!st_busy));
endmodule

// File: tb/lockstep_cmp_bench.sv
module lockstep_cmp_bench;
    localparam int W    = 8;
    localparam int NVEC = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en_main = 1'b1, en_chk = 1'b1;
    logic [W-1:0] in_a = '0, in_b = '0;
    logic         fault_clr = 1'b0, st_start = 1'b0, st_detail = 1'b0;
    logic [W-1:0] res_o;
    logic         fault_o, st_busy, st_done, st_pass;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lockstep_cmp #(.W(W), .NVEC(NVEC)) u_lockstep_cmp (
        .clk(clk), .rst_n(rst_n), .en_main(en_main), .en_chk(en_chk),
        .in_a(in_a), .in_b(in_b), .res_o(res_o), .fault_clr(fault_clr),
        .fault_o(fault_o), .st_start(st_start), .st_detail(st_detail),
        .st_busy(st_busy), .st_done(st_done), .st_pass(st_pass)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] vsum(input int k);
        return W'(37 * k + 11) + ~W'(13 * k);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    // Launch a test; lat counts edges from the start edge until done is seen.
    task automatic run_test(input bit detail, input int drop_at, input bit chk_res,
                            input int restart_at, input bit exp_pass, input int exp_lat);
        int lat;
        bit res_ok = 1'b1;
        bit fault_ok = 1'b1;
        st_detail = detail;
        st_start  = 1'b1;
        step();
        st_start = 1'b0;
        lat = 1;
        check(!st_done && st_busy, "R10 start clears done", int'(st_done), 0);
        while (!st_done && lat < 400) begin
            en_main  = (lat == drop_at) ? 1'b0 : 1'b1;
            st_start = (lat == restart_at);
            st_detail = (lat == restart_at) ? !detail : detail;
            step();
            lat++;
            if (chk_res && lat >= 2 && lat <= NVEC + 1 && res_o !== vsum(lat - 2))
                res_ok = 1'b0;
            if (fault_o) fault_ok = 1'b0;
        end
        en_main = 1'b1;
        st_start = 1'b0;
        st_detail = detail;
        check(lat == exp_lat, detail ? "R8 full-test latency" : "R7 quick-test latency", lat, exp_lat);
        check(st_pass == exp_pass, detail ? "R8 full-test verdict" : "R7 quick-test verdict",
              int'(st_pass), int'(exp_pass));
        check(!st_busy, "R6 busy low after done", int'(st_busy), 0);
        check(fault_ok, "R9 no mission fault during test", int'(fault_ok), 1);
        if (chk_res) check(res_ok, "R8 vectors reach main copy", int'(res_ok), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] exp_r;
        @(negedge clk);
        check(res_o == 0 && !fault_o && !st_busy && !st_done && !st_pass,
              "R1 reset state", int'(res_o), 0);
        do_reset();

        // R1/R2: sweep operand pairs
        for (int i = 0; i < 512; i++) begin
            in_a = W'(i);
            in_b = W'(i * 29 + 3 + (i >> 8) * 91);
            exp_r = in_a + in_b;
            step();
            check(res_o == exp_r, "R1 sum", int'(res_o), int'(exp_r));
        end
        check(!fault_o, "R2 no fault on clean traffic", int'(fault_o), 0);

        // R1 hold with both gaters off
        exp_r = res_o;
        en_main = 1'b0; en_chk = 1'b0;
        for (int i = 0; i < 3; i++) begin
            in_a = W'(i * 17 + 5); in_b = W'(i * 3 + 1);
            step();
        end
        check(res_o == exp_r, "R1 hold while disabled", int'(res_o), int'(exp_r));
        en_main = 1'b1; en_chk = 1'b1;
        for (int i = 0; i < 6; i++) begin
            in_a = W'(i * 41); in_b = W'(i * 7 + 2);
            step();
        end
        check(!fault_o, "R3 re-enable after idle", int'(fault_o), 0);

        // R3: main runs alone after reset, shadow joins later
        en_chk = 1'b0;
        do_reset();
        for (int i = 0; i < 6; i++) begin
            in_a = W'(i * 23 + 9); in_b = W'(i * 5 + 4);
            step();
        end
        en_chk = 1'b1;
        for (int i = 0; i < 10; i++) begin
            in_a = W'(i * 19 + 1); in_b = W'(i * 11 + 6);
            step();
        end
        check(!fault_o, "R3 warm-up suppresses stale compare", int'(fault_o), 0);

        // R4: main gater glitch while operands change
        in_a = 8'd10; in_b = 8'd20; step();
        en_main = 1'b0; in_a = 8'd33; in_b = 8'd44; step();
        en_main = 1'b1; in_a = 8'd55; in_b = 8'd66; step();
        step(); step();
        check(fault_o, "R4 glitch detected", int'(fault_o), 1);
        for (int i = 0; i < 10; i++) begin
            in_a = W'(i * 3); in_b = W'(i * 9);
            step();
        end
        check(fault_o, "R4 fault sticky", int'(fault_o), 1);

        // R5: clear
        fault_clr = 1'b1; step(); fault_clr = 1'b0;
        check(!fault_o, "R5 clear", int'(fault_o), 0);
        for (int i = 0; i < 10; i++) begin
            in_a = W'(i * 13); in_b = W'(i * 2);
            step();
        end
        check(!fault_o, "R5 stays clear", int'(fault_o), 0);

        // R7 quick test, healthy
        in_a = 8'd7; in_b = 8'd9;
        run_test(1'b0, -1, 1'b0, -1, 1'b1, W + 2);
        for (int i = 0; i < 5; i++) step();
        check(st_done && st_pass, "R10 verdict held", int'(st_pass), 1);

        // R8 full test, healthy, with an ignored restart (R6)
        run_test(1'b1, -1, 1'b1, 5, 1'b1, NVEC + 3);

        // R8 full test sabotaged by main gater glitch
        run_test(1'b1, 4, 1'b0, -1, 1'b0, NVEC + 3);
        step(); step();
        check(!fault_o, "R9 no fault after sabotaged test", int'(fault_o), 0);
        for (int i = 0; i < 4; i++) step();
        check(st_done && !st_pass, "R10 fail verdict held", int'(st_pass), 0);

        // R7 quick test sabotaged: shadow gater off
        in_a = 8'd3; in_b = 8'd4;
        step(); step();
        en_chk = 1'b0;
        run_test(1'b0, -1, 1'b0, -1, 1'b0, W + 2);
        en_chk = 1'b1;
        for (int i = 0; i < 4; i++) step();
        check(!fault_o, "R2 realigned after shadow gater restored", int'(fault_o), 0);

        // R7 healthy again
        run_test(1'b0, -1, 1'b0, -1, 1'b1, W + 2);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule